// File: doc/BRIEF.md
# UART Interrupt Identification Encoder

This block collects five interrupt conditions of a serial port and turns them into one read-only identification byte plus an interrupt request line. The five conditions are a receive line error, a receive data-available level, a receive character timeout level, a transmit holding register empty event and a modem input change. Each condition has its own enable bit. The block holds a pending flag for every condition and reports the highest-priority pending condition that is enabled.

Event sources (line error, transmit empty, modem change) arrive as one-cycle set pulses and are cleared by the pulse that matches their side effect. Level sources (data available, timeout) follow their input one clock later. Reading the identification byte while it reports transmit-empty clears that condition. The two upper bits of the byte show whether the FIFOs are enabled. The data path, FIFOs, baud timing and modem pins sit outside the block.

Top module: `uart_iid_enc`

## Requirements
- R1: After reset the identification byte reads 0x01, `irq_o` is low, and no condition is pending.
- R2: When no enabled condition is pending, bit 0 of the identification byte is 1 and bits [3:1] are 000.
- R3: The enabled pending condition of highest priority is reported in bits [3:0], with bit 0 = 0. The order from highest to lowest, with codes, is: line error 0110, data available 0100, timeout 1100, transmit empty 0010, modem change 0000. If data available and timeout are both pending, data available is reported.
- R4: Bits [5:4] always read 0. Bits [7:6] both equal `fifo_en`.
- R5: `src_en` bit 0 enables line error, bit 1 data available, bit 2 timeout, bit 3 transmit empty and bit 4 modem change. A disabled condition is neither reported nor raises `irq_o`, but it stays pending and is reported as soon as it is enabled.
- R6: `irq_o` is high exactly when at least one enabled condition is pending. It is combinational from the registered flags.
- R7: An `iir_rd` pulse in a cycle where the byte reports transmit empty clears that condition from the next cycle on. So does a `thr_wr` pulse. A read while another condition is reported leaves transmit empty pending.
- R8: A `thr_set` pulse in the same cycle as a clearing read or write leaves transmit empty pending.
- R9: `ls_clr` clears a pending line error and `ms_clr` clears a pending modem change. A set pulse in the same cycle as its clear leaves the condition pending.
- R10: The data-available and timeout conditions follow `rx_avail` and `rx_tmo` with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | FIFOs enabled; drives identification bits [7:6] |
| src_en | input | 5 | Enable per condition (see R5 for bit order) |
| ls_set | input | 1 | Line error event pulse |
| ls_clr | input | 1 | Line status read pulse; clears line error |
| rx_avail | input | 1 | Receive data available level |
| rx_tmo | input | 1 | Receive character timeout level |
| thr_set | input | 1 | Transmit holding register became empty |
| thr_wr | input | 1 | Write to transmit holding register; clears transmit empty |
| ms_set | input | 1 | Modem input change pulse |
| ms_clr | input | 1 | Modem status read pulse; clears modem change |
| iir_rd | input | 1 | Read of the identification byte |
| iir_o | output | 8 | Identification byte |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
Two things can land in the same cycle: the read that clears transmit empty and a new transmit-empty event. The same is true of the line-error and modem-change set and clear pulses. The bench first makes transmit empty the reported condition. It then drives `iir_rd` and `thr_set` together and expects transmit empty to be reported again afterwards. It does the same with `ls_set` plus `ls_clr` and with `ms_set` plus `ms_clr`. Around these cases the bench sweeps every pending pattern against every enable pattern in both FIFO modes. It compares the byte and the request line with a priority model written in the bench.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;
    localparam int NUM_SRC = 5;
    localparam int IIR_W   = 8;

    localparam int SRC_LS  = 0;
    localparam int SRC_RDA = 1;
    localparam int SRC_TMO = 2;
    localparam int SRC_THR = 3;
    localparam int SRC_MS  = 4;

    // identification bits [3:1] per source
    localparam logic [2:0] ID_LS  = 3'b011;
    localparam logic [2:0] ID_RDA = 3'b010;
    localparam logic [2:0] ID_TMO = 3'b110;
    localparam logic [2:0] ID_THR = 3'b001;
    localparam logic [2:0] ID_MS  = 3'b000;

    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
    } pend_st_t;
endpackage

// File: rtl/iid_pend_reg.sv
module iid_pend_reg
    import uart_iid_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] pend_d, pend_q;

    always_comb begin
        // set takes precedence over clear
        pend_d = (pend_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;

    for (genvar i = 0; i < N; i++) begin : g_chk
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> pend_q[i]); // R8
        AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !pend_q[i]); // R9
    end
endmodule

// File: rtl/iid_encoder.sv
module iid_encoder
    import uart_iid_pkg::*;
#(
    parameter int N = NUM_SRC,
    parameter int W = IIR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pend_i,
    input  logic [N-1:0] en_i,
    input  logic         fifo_i,
    output logic [N-1:0] grant_o,
    output logic [W-1:0] iir_o,
    output logic         irq_o
);
    logic [N-1:0] live;
    logic [2:0]   id;
    logic         found;

    assign live = pend_i & en_i;

    // lowest index wins: index order is priority order
    always_comb begin
        grant_o = '0;
        found   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!found && live[i]) begin
                grant_o[i] = 1'b1;
                found      = 1'b1;
            end
        end
    end

    always_comb begin
        id = 3'b000;
        if (grant_o[SRC_LS])       id = ID_LS;
        else if (grant_o[SRC_RDA]) id = ID_RDA;
        else if (grant_o[SRC_TMO]) id = ID_TMO;
        else if (grant_o[SRC_THR]) id = ID_THR;
        else if (grant_o[SRC_MS])  id = ID_MS;
    end

    assign irq_o = |live;
    assign iir_o = {{2{fifo_i}}, {(W-6){1'b0}}, id, ~irq_o};

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o)); // R3
    AST_IRQ_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (grant_o != '0)); // R6
    for (genvar i = 0; i < N; i++) begin : g_en
        AST_GRANT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
            grant_o[i] |-> (en_i[i] && pend_i[i])); // R5
    end
endmodule

// File: rtl/uart_iid_enc.sv
module uart_iid_enc
    import uart_iid_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic             ls_set,
    input  logic             ls_clr,
    input  logic             rx_avail,
    input  logic             rx_tmo,
    input  logic             thr_set,
    input  logic             thr_wr,
    input  logic             ms_set,
    input  logic             ms_clr,
    input  logic             iir_rd,
    output logic [IIR_W-1:0] iir_o,
    output logic             irq_o
);
    logic [NUM_SRC-1:0] set_d, clr_d, pend_q, grant;

    always_comb begin
        set_d          = '0;
        clr_d          = '0;
        set_d[SRC_LS]  = ls_set;
        clr_d[SRC_LS]  = ls_clr;
        set_d[SRC_RDA] = rx_avail;
        clr_d[SRC_RDA] = ~rx_avail;
        set_d[SRC_TMO] = rx_tmo;
        clr_d[SRC_TMO] = ~rx_tmo;
        set_d[SRC_THR] = thr_set;
        clr_d[SRC_THR] = thr_wr | (iir_rd & grant[SRC_THR]);
        set_d[SRC_MS]  = ms_set;
        clr_d[SRC_MS]  = ms_clr;
    end

    iid_pend_reg #(.N(NUM_SRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_d),
        .clr_i  (clr_d),
        .pend_o (pend_q)
    );

    iid_encoder #(.N(NUM_SRC), .W(IIR_W)) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_i  (pend_q),
        .en_i    (src_en),
        .fifo_i  (fifo_en),
        .grant_o (grant),
        .iir_o   (iir_o),
        .irq_o   (irq_o)
    );

    AST_THR_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && iir_o[3:0] == 4'b0010 && !thr_set) |=> !pend_q[SRC_THR]); // R7
    AST_RX_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q[SRC_RDA] == $past(rx_avail)); // R10
    AST_MID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        iir_o[5:4] == 2'b00); // R4
endmodule

// File: tb/uart_iid_enc_bench.sv
module uart_iid_enc_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0;
    logic [4:0] src_en = '0;
    logic       ls_set = 0, ls_clr = 0, rx_avail = 0, rx_tmo = 0;
    logic       thr_set = 0, thr_wr = 0, ms_set = 0, ms_clr = 0, iir_rd = 0;
    logic [7:0] iir_o;
    logic       irq_o;
    int         n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    uart_iid_enc u_uart_iid_enc (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .src_en(src_en),
        .ls_set(ls_set), .ls_clr(ls_clr), .rx_avail(rx_avail), .rx_tmo(rx_tmo),
        .thr_set(thr_set), .thr_wr(thr_wr), .ms_set(ms_set), .ms_clr(ms_clr),
        .iir_rd(iir_rd), .iir_o(iir_o), .irq_o(irq_o)
    );

    function automatic logic [7:0] model(logic [4:0] p, logic [4:0] e, logic f);
        logic [4:0] m;
        logic [3:0] id;
        m = p & e;
        if (m[0])      id = 4'b0110;
        else if (m[1]) id = 4'b0100;
        else if (m[2]) id = 4'b1100;
        else if (m[3]) id = 4'b0010;
        else if (m[4]) id = 4'b0000;
        else           id = 4'b0001;
        return {f, f, 2'b00, id};
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic release_pulses;
        ls_set = 0; ls_clr = 0; thr_set = 0; thr_wr = 0;
        ms_set = 0; ms_clr = 0; iir_rd = 0;
    endtask

    task automatic clear_all;
        ls_clr = 1; ms_clr = 1; thr_wr = 1; rx_avail = 0; rx_tmo = 0;
        tick;
        release_pulses;
    endtask

    task automatic raise(logic [4:0] p);
        ls_set = p[0]; rx_avail = p[1]; rx_tmo = p[2]; thr_set = p[3]; ms_set = p[4];
        tick;
        release_pulses;
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        tick; tick;
        chk("R1 iir", iir_o, 8'h01);
        chk("R1 irq", {7'b0, irq_o}, 8'h00);
        rst_n = 1'b1;
        tick;

        // R3 R4 R5 R6 sweep; R2 covered when p&e == 0
        for (int f = 0; f < 2; f++) begin
            for (int p = 0; p < 32; p++) begin
                fifo_en = f[0];
                raise(p[4:0]);
                for (int e = 0; e < 32; e++) begin
                    src_en = e[4:0];
                    #1;
                    chk("R3/R4/R5 R2 iir", iir_o, model(p[4:0], e[4:0], f[0]));
                    chk("R6 irq", {7'b0, irq_o}, {7'b0, |(p[4:0] & e[4:0])});
                end
                clear_all;
            end
        end

        fifo_en = 0;
        // R5 hidden pending surfaces when enabled
        src_en = 5'b01111;
        raise(5'b10000);
        chk("R5 masked", iir_o, 8'h01);
        src_en = 5'b11111; #1;
        chk("R5 unmasked", iir_o, 8'h00);
        clear_all;

        // R7 read reporting transmit empty clears it
        raise(5'b01000);
        chk("R7 pre", iir_o, 8'h02);
        iir_rd = 1; tick; release_pulses;
        chk("R7 cleared", iir_o, 8'h01);
        // R7 read while line error reported keeps transmit empty
        raise(5'b01001);
        iir_rd = 1; tick; release_pulses;
        chk("R7 ls shown", iir_o, 8'h06);
        ls_clr = 1; tick; release_pulses;
        chk("R7 thr kept", iir_o, 8'h02);
        // R7 write clears
        thr_wr = 1; tick; release_pulses;
        chk("R7 write clr", iir_o, 8'h01);

        // R8 read and new event in same cycle
        raise(5'b01000);
        iir_rd = 1; thr_set = 1; tick; release_pulses;
        chk("R8 set wins", iir_o, 8'h02);
        clear_all;

        // R9 line error and modem set/clear
        ls_set = 1; ls_clr = 1; tick; release_pulses;
        chk("R9 ls collide", iir_o, 8'h06);
        ls_clr = 1; tick; release_pulses;
        chk("R9 ls clr", iir_o, 8'h01);
        ms_set = 1; ms_clr = 1; tick; release_pulses;
        chk("R9 ms collide", iir_o, 8'h00);
        ms_clr = 1; tick; release_pulses;
        chk("R9 ms clr", iir_o, 8'h01);

        // R10 level sources track input with one cycle latency
        rx_tmo = 1; #1;
        chk("R10 not yet", iir_o, 8'h01);
        tick;
        chk("R10 tmo", iir_o, 8'h0C);
        rx_avail = 1; tick;
        chk("R10 rda first", iir_o, 8'h04);
        rx_avail = 0; rx_tmo = 0; tick;
        chk("R10 drop", iir_o, 8'h01);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule